// File: doc/BRIEF.md
# Multiplexed Address/Data Register Slave

This block puts a bank of byte-wide registers behind a narrow host bus on which the address and the data share the same eight lines. The host first places a register index on the lines, pulses the latch strobe high and brings it back low. The slave keeps that index. The host then selects the slave with the active-low chip select and pulses either the active-low write strobe, to store the byte on the lines, or the active-low read strobe, to have the slave drive the stored byte back.

The shared lines are modelled as three separate signals: an input, an output and an output enable. The strobes and the inbound data pass through two-flop synchronizers into the system clock domain, where edges are detected and the register bank is updated. The output enable is the exception. It is registered directly from the pins so that the slave releases the lines quickly.

A read and a write requested at the same time is treated as a host error. Nothing is written, nothing is driven, and an error pulse is raised.

Top module: `mrs_bus_slave`

## Requirements
- R1: After reset the stored index is 0, every register reads 0, the output enable is low and the error flag is low.
- R2: The index is taken from the bus input when the latch strobe falls, and only then. While the strobe is high or steady low, the index keeps its value, so back-to-back accesses reach the same register.
- R3: With chip select low, a byte on the bus input during a low write strobe is stored into the indexed register once the write strobe returns high. It can be read back afterwards.
- R4: With chip select low, the read strobe low and the write strobe high, the output enable is high and the bus output carries the indexed register.
- R5: If chip select is high during any part of a write strobe, the write is dropped and the register keeps its earlier value.
- R6: A read strobe given while chip select is high leaves the output enable low and the bus output at 0.
- R7: The output enable is high in a cycle only if, at the previous clock edge, chip select and read were low and write was high. It is low in the cycle after any of these conditions fails.
- R8: When read and write strobes are low together, no register is written and the output enable stays low.
- R9: Each overlap of read and write strobes raises the error flag for exactly one cycle. The flag rises three clock edges after the overlap is first sampled at the pins.
- R10: Whenever the output enable is low, the bus output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch strobe; the index is captured on its falling edge |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| bus_i | input | DATA_W | Inbound side of the shared address/data lines |
| bus_o | output | DATA_W | Outbound side of the shared lines |
| bus_oe_o | output | 1 | Drive enable for the shared lines |
| err_o | output | 1 | One-cycle pulse on a read/write strobe overlap |

## Verification
The timing checks assume that every pin level lasts several clock cycles. Under that assumption, the synchronized view of the strobes follows the pins with a fixed delay of two edges. The index-capture and error checks also assume that the bus input is stable for as long as the synchronizers need to pass a strobe edge. The bench changes every input on the falling clock edge and holds each level for at least three cycles. It changes the bus value only while the strobes that sample it are inactive, so every access stays inside these assumptions.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef struct packed {
    logic ale;
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/mrs_sync.sv
module mrs_sync #(
  parameter int unsigned     W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           strb_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              err_o
);
  logic              ale_q, wr_q, conf_q, wr_ok_q, err_q;
  logic [DATA_W-1:0] addr_q, wdat_q;
  logic              ale_fall, wr_rise, conflict, wr_ok_d;

  assign ale_fall = ale_q & ~strb_i.ale;
  assign wr_rise  = ~wr_q & strb_i.wr_n;
  assign conflict = ~strb_i.rd_n & ~strb_i.wr_n;
  // ok survives only if every low-strobe cycle saw cs low and no read
  assign wr_ok_d  = (wr_q ? 1'b1 : wr_ok_q) & ~strb_i.cs_n & strb_i.rd_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q   <= 1'b0;
      wr_q    <= 1'b1;
      conf_q  <= 1'b0;
      wr_ok_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
    end else begin
      ale_q  <= strb_i.ale;
      wr_q   <= strb_i.wr_n;
      conf_q <= conflict;
      err_q  <= conflict & ~conf_q;
      if (ale_fall) addr_q <= data_i;
      if (!strb_i.wr_n) begin
        wr_ok_q <= wr_ok_d;
        wdat_q  <= data_i;
      end
    end
  end

  assign addr_o  = addr_q;
  assign we_o    = wr_rise & wr_ok_q;
  assign wdata_o = wdat_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mrs_regfile.sv
module mrs_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                rows[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))      rows[i] <= wdata_i;
    end
  end

  assign rdata_o = rows[addr_i];
endmodule

// File: rtl/mrs_bus_slave.sv
module mrs_bus_slave
  import mrs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              err_o
);
  localparam int unsigned ADDR_W = DATA_W;

  strobe_t           strb_raw, strb_s;
  logic [DATA_W-1:0] data_s, addr_q, wdata, rdata;
  logic              we, oe_q;

  assign strb_raw = '{ale: ale_i, cs_n: cs_ni, rd_n: rd_ni, wr_n: wr_ni};

  mrs_sync #(.W($bits(strobe_t)), .RST_VAL(STROBE_IDLE)) u_sync_strb (
    .clk_i, .rst_ni, .d_i(strb_raw), .q_o(strb_s)
  );

  mrs_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(bus_i), .q_o(data_s)
  );

  mrs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .strb_i(strb_s), .data_i(data_s),
    .addr_o(addr_q), .we_o(we), .wdata_o(wdata), .err_o
  );

  mrs_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk_i, .rst_ni, .we_i(we), .addr_i(addr_q), .wdata_i(wdata), .rdata_o(rdata)
  );

  // enable taken straight from pins: one register, fast release of the lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= ~cs_ni & ~rd_ni & wr_ni;
  end

  assign bus_oe_o = oe_q;
  assign bus_o    = oe_q ? rdata : '0;
endmodule

// File: rtl/mrs_bus_slave_chk.sv
module mrs_bus_slave_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_i,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o,
  input logic              err_o,
  input logic [DATA_W-1:0] addr_i
);
  a_r7_oe_needs_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> $past(!cs_ni && !rd_ni && wr_ni));

  a_r7_oe_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(!cs_ni && !rd_ni && wr_ni) |-> !bus_oe_o);

  a_r9_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  a_r9_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(!rd_ni && !wr_ni, 3));

  a_r2_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != $past(addr_i)) |-> $past(ale_i, 4));

  a_r10_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_o == '0));
endmodule

bind mrs_bus_slave mrs_bus_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ale_i(ale_i), .cs_ni(cs_ni),
  .rd_ni(rd_ni), .wr_ni(wr_ni), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
  .err_o(err_o), .addr_i(addr_q)
);

// File: tb/sim_mrs_bus_slave.sv
module sim_mrs_bus_slave;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic          oe, err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;
  exp_t          exp_q[$];
  logic [DW-1:0] act_val;
  logic          act_oe;
  event          rd_ev;
  logic [DW-1:0] model [256];

  always #2 clk = ~clk;

  mrs_bus_slave #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe), .err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [DW-1:0] a);
    bus_in = a; ale = 1'b1; cyc(3);
    ale = 1'b0; cyc(5);
  endtask

  task automatic wr_byte(input logic [DW-1:0] a, input logic [DW-1:0] d);
    set_addr(a);
    cs_n = 1'b0; bus_in = d; cyc(1);
    wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(5);
    cs_n = 1'b1; cyc(1);
    model[a] = d;
  endtask

  // driver: queue the expectation, sample at the ports, notify the monitor
  task automatic rd_byte(input logic [DW-1:0] a, input string tag);
    set_addr(a);
    exp_q.push_back('{val: model[a], tag: tag});
    cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    act_val = bus_out; act_oe = oe;
    ->rd_ev;
    rd_n = 1'b1; cs_n = 1'b1; cyc(3);
  endtask

  initial begin : monitor
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", 0, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(act_oe === 1'b1, {e.tag, " oe"}, int'(act_oe), 1);
        check(act_val === e.val, e.tag, int'(act_val), int'(e.val));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 256; i++) model[i] = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    check(oe === 1'b0, "R1 oe after reset", int'(oe), 0);
    check(err === 1'b0, "R1 err after reset", int'(err), 0);
    check(bus_out === '0, "R10 bus idle", int'(bus_out), 0);
    // R1 index 0 and cleared registers: read without latching
    exp_q.push_back('{val: 8'h00, tag: "R1 reg0 after reset"});
    cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    act_val = bus_out; act_oe = oe; ->rd_ev;
    rd_n = 1'b1; cs_n = 1'b1; cyc(3);
    rd_byte(8'hC3, "R1 reg C3 after reset");

    // R3 / R4 writes and reads across patterns
    wr_byte(8'h10, 8'hA5);
    wr_byte(8'hFF, 8'h5A);
    wr_byte(8'h00, 8'h01);
    wr_byte(8'h7E, 8'h80);
    rd_byte(8'h10, "R3 write/read 10");
    rd_byte(8'hFF, "R4 read top index");
    rd_byte(8'h00, "R4 read index 0");
    rd_byte(8'h7E, "R3 write/read 7E");

    // R7 oe released one cycle after rd goes high
    set_addr(8'h10);
    cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    rd_n = 1'b1; cyc(1);
    check(oe === 1'b0, "R7 oe after rd high", int'(oe), 0);
    check(bus_out === '0, "R10 bus after release", int'(bus_out), 0);
    cs_n = 1'b1; cyc(2);

    // R2 index holds while ale high, repeated access same register
    set_addr(8'h7E);
    bus_in = 8'h10; ale = 1'b1; cyc(5);
    exp_q.push_back('{val: model[8'h7E], tag: "R2 ale high keeps index"});
    bus_in = 8'h10; cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    act_val = bus_out; act_oe = oe; ->rd_ev;
    rd_n = 1'b1; cs_n = 1'b1; cyc(3);
    ale = 1'b0; cyc(5);
    exp_q.push_back('{val: model[8'h10], tag: "R2 falling ale takes index"});
    cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    act_val = bus_out; act_oe = oe; ->rd_ev;
    rd_n = 1'b1; cs_n = 1'b1; cyc(3);
    exp_q.push_back('{val: model[8'h10], tag: "R2 repeat access"});
    cs_n = 1'b0; rd_n = 1'b0; cyc(3);
    act_val = bus_out; act_oe = oe; ->rd_ev;
    rd_n = 1'b1; cs_n = 1'b1; cyc(3);

    // R5 cs high mid-strobe drops the write
    set_addr(8'h10);
    cs_n = 1'b0; bus_in = 8'hEE; cyc(1);
    wr_n = 1'b0; cyc(4);
    cs_n = 1'b1; cyc(4);
    cs_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(5);
    cs_n = 1'b1; cyc(1);
    rd_byte(8'h10, "R5 write dropped");

    // R5 cs high through the whole strobe
    set_addr(8'h00);
    bus_in = 8'h33; wr_n = 1'b0; cyc(4);
    wr_n = 1'b1; cyc(5);
    rd_byte(8'h00, "R5 unselected write");

    // R6 read without cs
    set_addr(8'hFF);
    rd_n = 1'b0;
    begin
      bit seen = 0;
      for (int i = 0; i < 6; i++) begin
        cyc(1);
        if (oe !== 1'b0 || bus_out !== '0) seen = 1;
      end
      check(!seen, "R6 unselected read", int'(seen), 0);
    end
    rd_n = 1'b1; cyc(3);

    // R8 / R9 overlap of read and write strobes
    set_addr(8'h7E);
    bus_in = 8'h99; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    begin
      int err_cnt = 0;
      int err_at = -1;
      bit oe_seen = 0;
      for (int i = 1; i <= 10; i++) begin
        cyc(1);
        if (err === 1'b1) begin
          err_cnt++;
          if (err_at < 0) err_at = i;
        end
        if (oe === 1'b1) oe_seen = 1;
      end
      rd_n = 1'b1; wr_n = 1'b1; cyc(5);
      cs_n = 1'b1; cyc(1);
      check(err_cnt == 1, "R9 err pulse width", err_cnt, 1);
      check(err_at == 3, "R9 err latency", err_at, 3);
      check(!oe_seen, "R8 no drive on overlap", int'(oe_seen), 0);
    end
    rd_byte(8'h7E, "R8 no write on overlap");

    cyc(4);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule